// File: doc/BRIEF.md
# Write-Once RAM Base Register with Array Decode

This block holds the relocation base of an on-chip RAM array inside a 24-bit address space and turns that base into an array-select for incoming bus addresses. Software programs the base once through a 16-bit register port with two byte-lane enables. The first accepted write locks the register until the next master reset, so stray software cannot move the array later. A read-only disabled flag keeps the array from answering any address until the base field has been written. The register port itself keeps working whether the array is enabled or not.

The stored field is the upper eleven bits of the array's address, so the array always starts on an 8 KB boundary. Bus bits [12:0] pass straight through as the offset into the array. A soft reset leaves the base, the lock and the flag alone. It only clears the read-data holding register.

Top module: `ram_base_ctrl`

## Requirements
- R1: After master reset `rd_data` is 0x0000 and `arr_sel` is 0 for every bus address.
- R2: A read (`reg_sel`=1, `reg_wr`=0) loads `rd_data` on the next clock edge with {field[10:0] in bits 15:5, zeros in bits 4:1, disabled flag in bit 0}. `rd_data` holds its value when there is no read.
- R3: Only the first accepted write after master reset changes the register. Every later write is ignored.
- R4: Lane `reg_be[1]` covers data bits 15:8, which is field[10:3]. Lane `reg_be[0]` covers bits 7:0, of which bits 7:5 are field[2:0]. A lane left out of the first write can never be changed until master reset.
- R5: The disabled flag starts at 1. It clears only when the first accepted write includes `reg_be[1]`. A first write with only `reg_be[0]` locks the register but leaves the array disabled.
- R6: Write data in bits 4:0 is ignored, and bits 4:1 always read as zero.
- R7: `arr_sel` is 1 exactly when the flag is 0 and `bus_addr[23:13]` equals the field. It follows the current address and state in the same cycle. `arr_ofs` always equals `bus_addr[12:0]`.
- R8: `soft_rst` does not change the field, the lock or the flag, and a write in the same cycle still takes effect. On the following edge `rd_data` becomes 0x0000, and this wins over a read in the same cycle.
- R9: A write strobe with both lane enables at 0 is not accepted: it changes nothing and does not lock the register.
- R10: Reads are served while the array is disabled. The first read after reset returns 0x0001.
- R11: Master reset restores the unlocked state, a field of 0 and a flag of 1, so a new first write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_be | input | 2 | Byte-lane enables (bit 1 = upper byte) |
| reg_wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| bus_addr | input | 24 | Bus address to decode |
| arr_sel | output | 1 | Array selected for `bus_addr` |
| arr_ofs | output | 13 | Offset within the array |

## Verification
The first base write can arrive in the same cycle as a soft reset, and in that same cycle a bus address that matches the new base can be presented to the decoder. The bench drives all three together. It expects the write to land despite the soft reset, the decoder to stay off for that cycle because it still sees the old state, and the select to come on in the next cycle. A behavioural model compares `rd_data`, `arr_sel` and `arr_ofs` on every clock, so any ordering slip between the write, the read holding register and the decode shows up as a mismatch in the cycle where it happens.

// File: rtl/rbase_pkg.sv
package rbase_pkg;

    localparam int REG_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES = REG_W / LANE_W;

    typedef struct packed {
        logic             go;
        logic [LANES-1:0] be;
        logic [REG_W-1:0] data;
    } wr_req_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    function automatic acc_kind_t classify(input logic sel, input logic wr,
                                           input logic [LANES-1:0] be);
        if (!sel)
            return ACC_IDLE;
        if (!wr)
            return ACC_READ;
        if (|be)
            return ACC_WRITE;
        return ACC_IDLE;
    endfunction

    function automatic int lane_of(input int bit_pos);
        return bit_pos / LANE_W;
    endfunction

endpackage

// File: rtl/rbase_store.sv
module rbase_store
    import rbase_pkg::*;
#(
    parameter int FIELD_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wreq,
    output logic [FIELD_W-1:0] field,
    output logic               dis,
    output logic               locked
);
    localparam int FIELD_LSB = REG_W - FIELD_W;

    logic               accept;
    logic [FIELD_W-1:0] bit_wen;
    logic [FIELD_W-1:0] field_nxt;
    logic               top_lane;

    assign accept   = wreq.go && !locked;
    assign top_lane = wreq.be[LANES-1];

    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
        localparam int LN = lane_of(FIELD_LSB + i);
        assign bit_wen[i]   = accept && wreq.be[LN];
        assign field_nxt[i] = bit_wen[i] ? wreq.data[FIELD_LSB + i] : field[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field  <= '0;
            dis    <= 1'b1;
            locked <= 1'b0;
        end else begin
            field <= field_nxt;
            if (accept) begin
                locked <= 1'b1;
                if (top_lane)
                    dis <= 1'b0;
            end
        end
    end

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);
    assert_field_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(field));
    assert_flag_no_rise_R5: assert property (@(posedge clk) disable iff (rst)
        !dis |=> !dis);
    assert_flag_needs_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (dis && !(wreq.go && wreq.be[LANES-1])) |=> dis);
    assert_empty_write_R9: assert property (@(posedge clk) disable iff (rst)
        (!wreq.go && !locked) |=> !locked);

endmodule

// File: rtl/rbase_decode.sv
module rbase_decode #(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-OFS_W-1:0] field,
    input  logic              dis,
    output logic              arr_sel,
    output logic [OFS_W-1:0]  arr_ofs
);
    logic hit;

    always_comb begin
        hit     = (bus_addr[ADDR_W-1:OFS_W] == field);
        arr_sel = hit && !dis;
        arr_ofs = bus_addr[OFS_W-1:0];
    end

    assert_sel_gated_R7: assert property (@(posedge clk) disable iff (rst)
        arr_sel |-> !dis);
    assert_sel_matches_R7: assert property (@(posedge clk) disable iff (rst)
        arr_sel |-> (bus_addr[ADDR_W-1:OFS_W] == field));

endmodule

// File: rtl/rbase_rdport.sv
module rbase_rdport
    import rbase_pkg::*;
#(
    parameter int FIELD_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               rd_go,
    input  logic [FIELD_W-1:0] field,
    input  logic               dis,
    output logic [REG_W-1:0]   rd_data
);
    localparam int RSV_W = REG_W - FIELD_W - 1;

    logic [REG_W-1:0] image;

    always_comb image = {field, {RSV_W{1'b0}}, dis};

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            rd_data <= '0;
        else if (rd_go)
            rd_data <= image;
    end

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
        rd_data[RSV_W:1] == '0);
    assert_soft_clears_R8: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> rd_data == '0);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!rd_go && !soft_rst) |=> $stable(rd_data));

endmodule

// File: rtl/ram_base_ctrl.sv
module ram_base_ctrl
    import rbase_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [1:0]        reg_be,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       rd_data,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              arr_sel,
    output logic [OFS_W-1:0]  arr_ofs
);
    localparam int FIELD_W = ADDR_W - OFS_W;

    acc_kind_t          kind;
    wr_req_t            wreq;
    logic [FIELD_W-1:0] field;
    logic               dis;
    logic               locked;

    always_comb begin
        kind      = classify(reg_sel, reg_wr, reg_be);
        wreq.go   = (kind == ACC_WRITE);
        wreq.be   = reg_be;
        wreq.data = reg_wdata;
    end

    rbase_store #(.FIELD_W(FIELD_W)) u_store (
        .clk(clk), .rst(rst), .wreq(wreq),
        .field(field), .dis(dis), .locked(locked)
    );

    rbase_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dec (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .field(field), .dis(dis),
        .arr_sel(arr_sel), .arr_ofs(arr_ofs)
    );

    rbase_rdport #(.FIELD_W(FIELD_W)) u_rd (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .rd_go(kind == ACC_READ), .field(field), .dis(dis), .rd_data(rd_data)
    );

    assert_soft_keeps_state_R8: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !wreq.go) |=> ($stable(field) && $stable(dis) && $stable(locked)));

endmodule

// File: tb/ram_base_ctrl_tb_top.sv
`timescale 1ns/1ps
module ram_base_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst, soft_rst, reg_sel, reg_wr;
    logic [1:0]  reg_be;
    logic [15:0] reg_wdata, rd_data;
    logic [23:0] bus_addr;
    logic        arr_sel;
    logic [12:0] arr_ofs;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_field, m_dis, m_lock, m_rd;

    always #4 clk = ~clk;

    ram_base_ctrl dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .rd_data(rd_data), .bus_addr(bus_addr), .arr_sel(arr_sel),
        .arr_ofs(arr_ofs)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare, then advance the model at posedge
    task automatic step(bit r, bit s, bit sel, bit wr, int be, int wd, int addr);
        @(negedge clk);
        rst = r; soft_rst = s; reg_sel = sel; reg_wr = wr;
        reg_be = be[1:0]; reg_wdata = wd[15:0]; bus_addr = addr[23:0];
        #1;
        check({cur_req, " rd_data (R2)"}, rd_data, m_rd);
        check({cur_req, " arr_sel (R7)"}, arr_sel,
              (m_dis == 0 && ((addr >> 13) & 'h7FF) == m_field) ? 1 : 0);
        check({cur_req, " arr_ofs (R7)"}, arr_ofs, addr & 'h1FFF);
        @(posedge clk);
        if (r) begin
            m_field = 0; m_dis = 1; m_lock = 0; m_rd = 0;
        end else begin
            if (s) m_rd = 0;
            else if (sel && !wr) m_rd = (m_field << 5) | m_dis;
            if (sel && wr && be != 0 && !m_lock) begin
                if (be & 2) begin
                    m_field = (m_field & 'h7) | (((wd >> 8) & 'hFF) << 3);
                    m_dis = 0;
                end
                if (be & 1) m_field = (m_field & 'h7F8) | ((wd >> 5) & 'h7);
                m_lock = 1;
            end
        end
    endtask

    task automatic idle(int addr); step(0, 0, 0, 0, 0, 0, addr); endtask
    task automatic rd(); step(0, 0, 1, 0, 0, 0, 0); endtask
    task automatic wr(int be, int wd); step(0, 0, 1, 1, be, wd, 0); endtask

    task automatic expect_reg(string req, int v);
        rd();
        idle(0);
        check(req, rd_data, v);
    endtask

    initial begin
        m_field = 0; m_dis = 1; m_lock = 0; m_rd = 0;
        rst = 1; soft_rst = 0; reg_sel = 0; reg_wr = 0;
        reg_be = 0; reg_wdata = 0; bus_addr = 0;
        @(posedge clk);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);

        cur_req = "R1";
        idle(0);
        check("R1 rd_data after reset", rd_data, 0);
        check("R1 arr_sel off", arr_sel, 0);

        cur_req = "R10";
        expect_reg("R10 read while disabled", 'h0001);

        cur_req = "R9";
        wr(0, 'hFFA0);
        expect_reg("R9 empty-lane write ignored", 'h0001);

        cur_req = "R8";
        step(0, 1, 1, 1, 3, 'hFFBF, 'hFFA123);
        check("R8 decode still off in write cycle", arr_sel, 0);
        idle('hFFA123);
        check("R8 write during soft reset landed", arr_sel, 1);
        check("R8 soft reset cleared rd_data", rd_data, 0);

        cur_req = "R6";
        expect_reg("R6 reserved and flag bits ignored", 'hFFA0);

        cur_req = "R7";
        idle('hFFA000); check("R7 low edge", arr_sel, 1);
        idle('hFFBFFF); check("R7 high edge", arr_sel, 1);
        idle('hFF9FFF); check("R7 below", arr_sel, 0);
        idle('hFFC000); check("R7 above", arr_sel, 0);

        cur_req = "R3";
        wr(3, 'h1234);
        expect_reg("R3 second write ignored", 'hFFA0);
        idle('hFFA010); check("R3 decode unchanged", arr_sel, 1);

        cur_req = "R8";
        step(0, 1, 1, 0, 0, 0, 0);
        idle(0);
        check("R8 soft reset beats read", rd_data, 0);
        expect_reg("R8 register kept", 'hFFA0);

        cur_req = "R11";
        step(1, 0, 0, 0, 0, 0, 0);
        expect_reg("R11 reset restores 0x0001", 'h0001);

        cur_req = "R5";
        wr(1, 'h00E0);
        expect_reg("R5 lower-only write keeps disabled", 'h00E1);
        cur_req = "R4";
        wr(2, 'hAB00);
        expect_reg("R4 upper lane blocked", 'h00E1);
        idle('h00E000); check("R5 array stays off", arr_sel, 0);

        cur_req = "R4";
        step(1, 0, 0, 0, 0, 0, 0);
        wr(2, 'hABFF);
        expect_reg("R4 upper-only write", 'hAB00);
        wr(1, 'h00E0);
        expect_reg("R4 lower lane blocked", 'hAB00);
        idle('hAB0000); check("R5 upper write enables", arr_sel, 1);
        idle('hAB2000); check("R7 next block off", arr_sel, 0);

        cur_req = "R2";
        repeat (3) idle('h123456);
        check("R2 rd_data held", rd_data, 'hAB00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule